// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Request Unit

This block keeps the interrupt state for four peripheral event sources: a key wakeup, a serial bus collision detector, a converter-done signal and a timer. Each source has an enable bit written by software, a sticky flag bit and a pending request output. A flag records every event from its source, whether or not that source is enabled. A pending request is raised only for enabled sources.

Software reaches the block through a small register port with two addresses: an enable register and a flag register. Flags are cleared by writing zero to the bits to be cleared and one to every other bit, so one flag can be cleared without a read-modify-write race against the others. Pending requests are dropped by a per-source acknowledge input from the interrupt controller. Source events are single-cycle pulses in the block's clock domain.

Top module: `intsrc_status`

## Requirements
- R1: While reset is held, and in the first cycles after release, all flags, enable bits and pending requests are 0 and both registers read 0x00.
- R2: An event pulse on src_event[i] sets flag bit i on the next clock edge, whatever the value of enable bit i. Bit order is 0 key wakeup, 1 bus collision, 2 converter done, 3 timer.
- R3: An event pulse on src_event[i] sets irq_req[i] on the next clock edge only if enable bit i was 1 before that edge; with the enable bit at 0 the request stays 0.
- R4: A write to the flag register (reg_addr = 1) clears flag bit i where reg_wdata[i] is 0 and leaves flag bit i unchanged where reg_wdata[i] is 1; a write never sets a flag.
- R5: reg_addr = 0 selects the enable register: a write stores reg_wdata[3:0]. Both registers return their four bits in reg_rdata[3:0], and reg_rdata[7:4] always reads 0.
- R6: When an event on source i and a flag-register write with reg_wdata[i] = 0 come in the same cycle, flag bit i ends up set.
- R7: A pulse on req_ack[i] clears irq_req[i] on the next edge and leaves the flags unchanged; if an enabled event on source i comes in the same cycle as its acknowledge, irq_req[i] stays set.
- R8: Writing the enable register does not change pending requests already raised, and an event in the same cycle as an enable write is gated by the enable value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable, 1 flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| src_event | input | 4 | Single-cycle event pulses, one per source |
| req_ack | input | 4 | Per-source acknowledge of a pending request |
| irq_req | output | 4 | Pending request per source |

## Verification
The hardest situations to reach are the same-cycle collisions: an event landing in exactly the cycle of a clearing flag write, of an acknowledge, or of an enable write. The bench drives all inputs on the falling edge, so it can place an event pulse and a register write or acknowledge in the same cycle deliberately, then reads the flag register and the request outputs one edge later to see which side won. Disabled-source events are checked by reading the flag register back while the request output is observed to stay low.

// File: rtl/isd_pkg.sv
package isd_pkg;
  localparam int ISD_NUM_SRC = 4;
  localparam int ISD_DATA_W  = 8;

  typedef enum logic {
    ISD_ADDR_ENABLE = 1'b0,
    ISD_ADDR_FLAG   = 1'b1
  } isd_addr_e;

  typedef enum int {
    ISD_SRC_KEYWAKE  = 0,
    ISD_SRC_BUSCOLL  = 1,
    ISD_SRC_CONVDONE = 2,
    ISD_SRC_TIMER    = 3
  } isd_src_e;
endpackage

// File: rtl/isd_rst_sync.sv
module isd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/isd_flag_bank.sv
module isd_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_event,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_keep,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_en;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_en[i] = src_event[i] | (clr_wr & ~clr_keep[i]);
      // An event outranks a same-cycle clearing write
      flag_d[i]  = src_event[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/isd_req_bank.sv
module isd_req_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_event,
  input  logic [N-1:0] valid,
  input  logic [N-1:0] ack,
  output logic [N-1:0] req_q
);
  logic [N-1:0] req_d;
  logic [N-1:0] req_en;
  logic [N-1:0] req_set;

  for (genvar i = 0; i < N; i++) begin : g_req
    always_comb begin
      req_set[i] = src_event[i] & valid[i];
      req_en[i]  = req_set[i] | ack[i];
      // A gated event outranks a same-cycle acknowledge
      req_d[i]   = req_set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         req_q[i] <= 1'b0;
      else if (req_en[i]) req_q[i] <= req_d[i];
    end
  end
endmodule

// File: rtl/isd_regif.sv
module isd_regif
  import isd_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_addr,
  input  logic [W-1:0] reg_wdata,
  input  logic [N-1:0] flag_q,
  output logic [N-1:0] valid_q,
  output logic         flag_wr,
  output logic [N-1:0] flag_keep,
  output logic [W-1:0] reg_rdata
);
  localparam int PAD_W = W - N;

  logic         valid_en;
  logic [N-1:0] valid_d;
  logic         unused_wdata_hi;

  always_comb begin
    valid_en  = reg_wr && (reg_addr == ISD_ADDR_ENABLE);
    valid_d   = reg_wdata[N-1:0];
    flag_wr   = reg_wr && (reg_addr == ISD_ADDR_FLAG);
    flag_keep = reg_wdata[N-1:0];
  end

  assign unused_wdata_hi = ^reg_wdata[W-1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid_q <= '0;
    else if (valid_en) valid_q <= valid_d;
  end

  always_comb begin
    if (reg_addr == ISD_ADDR_FLAG) reg_rdata = {{PAD_W{1'b0}}, flag_q};
    else                           reg_rdata = {{PAD_W{1'b0}}, valid_q};
  end
endmodule

// File: rtl/intsrc_status.sv
module intsrc_status
  import isd_pkg::*;
#(
  parameter int NUM_SRC = ISD_NUM_SRC,
  parameter int DATA_W  = ISD_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic [NUM_SRC-1:0] req_ack,
  output logic [NUM_SRC-1:0] irq_req
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] valid_q;
  logic               flag_wr;
  logic [NUM_SRC-1:0] flag_keep;

  isd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  isd_regif #(.N(NUM_SRC), .W(DATA_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flag_q    (flag_q),
    .valid_q   (valid_q),
    .flag_wr   (flag_wr),
    .flag_keep (flag_keep),
    .reg_rdata (reg_rdata)
  );

  isd_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_event (src_event),
    .clr_wr    (flag_wr),
    .clr_keep  (flag_keep),
    .flag_q    (flag_q)
  );

  isd_req_bank #(.N(NUM_SRC)) u_reqs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_event (src_event),
    .valid     (valid_q),
    .ack       (req_ack),
    .req_q     (irq_req)
  );
endmodule

// File: rtl/isd_checker.sv
module isd_checker #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         reg_wr,
  input logic         reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] reg_rdata,
  input logic [N-1:0] src_event,
  input logic [N-1:0] req_ack,
  input logic [N-1:0] irq_req,
  input logic [N-1:0] flag_q,
  input logic [N-1:0] valid_q
);
  // R2 and R6: every event leaves its flag set one edge later
  assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|src_event) |=> ((flag_q & $past(src_event)) == $past(src_event)));

  // R3: a new request needs the enable bit held before the edge
  assert_req_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $changed(irq_req) |-> ((irq_req & ~$past(irq_req) & ~$past(valid_q)) == '0));

  // R4: writing one to a flag bit keeps it and never sets a clear bit
  assert_write_one_keeps_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr) |=>
      (((($past(flag_q) & $past(reg_wdata[N-1:0])) & ~flag_q) == '0) &&
       (((~$past(flag_q) & ~$past(src_event)) & flag_q) == '0)));

  // R5: upper read bits are always zero
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rdata[W-1:N] == '0);

  // R7: an acknowledge without an event drops the request, flags untouched
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|req_ack) |=> (((($past(req_ack) & ~$past(src_event)) & irq_req) == '0) &&
                    ((($past(flag_q) & ~flag_q) & ~($past({N{reg_wr && reg_addr}}))) == '0)));
endmodule

bind intsrc_status isd_checker #(.N(NUM_SRC), .W(DATA_W)) u_isd_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .src_event  (src_event),
  .req_ack    (req_ack),
  .irq_req    (irq_req),
  .flag_q     (flag_q),
  .valid_q    (valid_q)
);

// File: tb/test_intsrc_status.sv
`timescale 1ns/1ps
module test_intsrc_status;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic       reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [3:0] src_event;
  logic [3:0] req_ack;
  logic [3:0] irq_req;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  intsrc_status i_intsrc_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_event (src_event),
    .req_ack   (req_ack),
    .irq_req   (irq_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    reg_wr = 1'b0; src_event = '0; req_ack = '0;
  endtask

  // drive one cycle of stimulus, then return at the following falling edge
  task automatic drive(input logic wr, input logic addr, input logic [7:0] d,
                       input logic [3:0] ev, input logic [3:0] ak);
    @(negedge clk);
    reg_wr = wr; reg_addr = addr; reg_wdata = d; src_event = ev; req_ack = ak;
    @(negedge clk);
    reg_wr = 1'b0; src_event = '0; req_ack = '0;
  endtask

  task automatic read_reg(input logic addr, output logic [7:0] v);
    reg_addr = addr;
    #1 v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    read_reg(1'b0, v); chk("R1 enable after reset", v, 8'h00);
    read_reg(1'b1, v); chk("R1 flags after reset", v, 8'h00);
    chk("R1 irq after reset", irq_req, 4'h0);
  endtask

  task automatic t_disabled_event();
    logic [7:0] v;
    drive(1'b0, 1'b0, 8'h00, 4'b0001, 4'b0000);
    read_reg(1'b1, v); chk("R2 flag on disabled source", v, 8'h01);
    chk("R3 no request from disabled source", irq_req, 4'h0);
  endtask

  task automatic t_enabled_event();
    logic [7:0] v;
    drive(1'b1, 1'b0, 8'hF6, 4'b0000, 4'b0000);
    read_reg(1'b0, v); chk("R5 enable readback, upper zero", v, 8'h06);
    drive(1'b0, 1'b0, 8'h00, 4'b0010, 4'b0000);
    read_reg(1'b1, v); chk("R2 flag on enabled source", v, 8'h03);
    chk("R3 request from enabled source", irq_req, 4'h2);
  endtask

  task automatic t_ack();
    logic [7:0] v;
    drive(1'b0, 1'b0, 8'h00, 4'b0000, 4'b0010);
    chk("R7 ack clears request", irq_req, 4'h0);
    read_reg(1'b1, v); chk("R7 ack leaves flags", v, 8'h03);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    drive(1'b1, 1'b1, 8'hFE, 4'b0000, 4'b0000);
    read_reg(1'b1, v); chk("R4 write zero clears one flag", v, 8'h02);
    drive(1'b1, 1'b1, 8'hFF, 4'b0000, 4'b0000);
    read_reg(1'b1, v); chk("R4 write ones changes nothing", v, 8'h02);
  endtask

  task automatic t_event_vs_clear();
    logic [7:0] v;
    drive(1'b1, 1'b1, 8'h00, 4'b1000, 4'b0000);
    read_reg(1'b1, v); chk("R6 event beats clearing write", v, 8'h08);
    chk("R3 timer disabled gives no request", irq_req, 4'h0);
  endtask

  task automatic t_event_vs_ack();
    drive(1'b0, 1'b0, 8'h00, 4'b0100, 4'b0000);
    chk("R3 converter request raised", irq_req, 4'h4);
    drive(1'b0, 1'b0, 8'h00, 4'b0100, 4'b0100);
    chk("R7 event beats ack", irq_req, 4'h4);
  endtask

  task automatic t_enable_change();
    logic [7:0] v;
    drive(1'b1, 1'b0, 8'h00, 4'b0000, 4'b0000);
    chk("R8 disable keeps pending request", irq_req, 4'h4);
    drive(1'b1, 1'b0, 8'h01, 4'b0001, 4'b0000);
    chk("R8 event uses enable before write", irq_req, 4'h4);
    read_reg(1'b1, v); chk("R8 flag still recorded", v, 8'h0D);
    read_reg(1'b0, v); chk("R5 enable register value", v, 8'h01);
    drive(1'b0, 1'b0, 8'h00, 4'b0001, 4'b0000);
    chk("R3 newly enabled source requests", irq_req, 4'h5);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    src_event = '0; req_ack = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) idle_cycle();
    t_reset();
    t_disabled_event();
    t_enabled_event();
    t_ack();
    t_clear();
    t_event_vs_clear();
    t_event_vs_ack();
    t_enable_change();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule